// File: doc/BRIEF.md
# Raster Timing Generator with Border

This block produces the raster timing for a video output. A pair of scan counters (column and line), advanced by a pixel-clock enable, are decoded against a programmed register set. The decoding yields active-low horizontal and vertical sync, a flag for the visible border rectangle and a flag for a display window placed inside that rectangle. In the border the block outputs a programmable border colour. In the window it passes through pixel data supplied from outside. While the window is active it reports the pixel and line index that an external fetch unit should supply.

The programmed values arrive on input words whose bit layout is fixed. They act as a shadow set. They are copied into the active set on the enabled clock where the scan reaches column 0 of the line at the vertical border stop, which is the first clock of vertical sync. They are also copied once on the first enabled clock after reset. Further modes are a blank control that turns the whole visible rectangle into border, horizontal pixel doubling, scan doubling, and interlace with a long and a short field. The rectangle start and stop positions also bound the sync intervals. Each sync runs from the border stop, wraps through zero and ends at the border start.

Top module: `raster_timing_gen`

## Requirements
- R1: The column counter advances by one on each clock with `pix_en` high and wraps from (line total − 1) to 0. The line counter advances on each column wrap and wraps after the last line of the field. Neither moves while `pix_en` is low. `cfg_size` holds the line total in clocks in [15:0] and the field total in lines in [31:16].
- R2: In reset the active set is all zero, so both syncs are high and `rgb_out` is 0. The first enabled clock after reset loads the active set and keeps the position at column 0, line 0. Counting starts on the next enabled clock.
- R3: A change on any `cfg_*` input takes effect only through the copy described in R2, or on the enabled clock where the column wraps to 0 and the line becomes the active vertical border stop.
- R4: `hsync_n` is low when column ≥ horizontal border stop or column < horizontal border start. `cfg_hbrd` holds the start in [31:16] and the stop in [15:0]. `vsync_n` follows the same rule with the line and `cfg_vbrd`. Both are held high while video enable (`cfg_sync` bit 8) is 0.
- R5: The visible rectangle is the set of positions where neither sync rule of R4 holds. `window_act` is high inside the rectangle when two conditions both hold. The column must lie in [window start, start + width·k) with k = 2 under pixel doubling, else 1. The line must lie in [vertical start, start + height·m) with m = 2 under scan doubling, else 1. `cfg_wsize` holds the width in [15:0] and the height in [31:16]. `border_act` is high inside the rectangle wherever `window_act` is low.
- R6: The blank bit (`cfg_wincfg` bit 3) holds `window_act` low so that `border_act` covers the whole rectangle. The syncs are unchanged.
- R7: Pixel doubling (`cfg_wincfg` bit 0) makes `win_x` equal to (column − window start) / 2, so each pixel index holds for two clocks. Otherwise `win_x` equals column − window start.
- R8: Scan doubling (`cfg_mode` bit 1) makes the local window line (line − vertical start) / 2, so each line index is output on two lines.
- R9: Interlace (`cfg_sync` bit 4) toggles `field_odd` at each field wrap. Field 0 is the long field with field total + 1 lines, and field 1 has field total lines. The vertical window start is `cfg_wvstart`[15:0] in field 0 and [31:16] in field 1. `win_y` is 2·local line + `field_odd`. Without interlace `field_odd` is cleared on the next enabled clock.
- R10: `rgb_out` is `pix_rgb` while `window_act` is high, the border colour while `border_act` is high, and 0 elsewhere. `rgb_sel_pix` equals `window_act`.
- R11: Display enable (`cfg_mode` bit 0) at 0 forces `rgb_out` to 0 while counters and syncs keep running. Video enable at 0 also forces `rgb_out` to 0.
- R12: Outside the window, `win_x` and `win_y` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable |
| cfg_size | input | 32 | Field total [31:16], line total [15:0] |
| cfg_hbrd | input | 32 | Horizontal border start [31:16], stop [15:0] |
| cfg_vbrd | input | 32 | Vertical border start [31:16], stop [15:0] |
| cfg_whstart | input | 16 | Window horizontal start |
| cfg_wvstart | input | 32 | Window vertical start, field 1 [31:16], field 0 [15:0] |
| cfg_wsize | input | 32 | Window height [31:16], width [15:0] in fetched pixels and lines |
| cfg_wincfg | input | 32 | Bit 3 blank, bit 0 pixel doubling |
| cfg_mode | input | 32 | Bit 1 scan doubling, bit 0 display enable |
| cfg_sync | input | 32 | Bit 8 video enable, bit 4 interlace |
| cfg_border_rgb | input | 24 | Border colour |
| pix_rgb | input | 24 | Pixel data for the current window position |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| border_act | output | 1 | Position is border |
| window_act | output | 1 | Position is inside the display window |
| field_odd | output | 1 | Current interlace field |
| win_x | output | 16 | Window pixel index |
| win_y | output | 16 | Window line index |
| rgb_sel_pix | output | 1 | Colour output is taken from pixel data |
| rgb_out | output | 24 | Colour output |

## Verification
The shadow copy and a fresh program write can fall on the same enabled clock. So can the copy and an interlace change while the scan is in the short field, which decides the length of the next field. To provoke both, the bench runs a stretch in which the blank, doubling, enables, interlace, vertical starts and border colour are changed on every clock. Some change therefore lands on the loading edge. A behavioural model checks every output on every clock and copies the inputs exactly where R3 says. A capture one clock early or late, or a field length taken from the wrong interlace value, shows up as a miscompare.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int FW = 16;

  typedef struct packed {
    logic [FW-1:0] htot;
    logic [FW-1:0] vtot;
    logic [FW-1:0] hbs;
    logic [FW-1:0] hbe;
    logic [FW-1:0] vbs;
    logic [FW-1:0] vbe;
    logic [FW-1:0] whs;
    logic [FW-1:0] wv_long;
    logic [FW-1:0] wv_short;
    logic [FW-1:0] wwid;
    logic [FW-1:0] whgt;
    logic          pix_dbl;
    logic          blank;
    logic          scan_dbl;
    logic          disp_en;
    logic          ilace;
    logic          video_en;
  } rtg_cfg_t;
endpackage

// File: rtl/rtg_shadow.sv
module rtg_shadow
  import rtg_pkg::*;
#(
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [31:0]      cfg_size,
  input  logic [31:0]      cfg_hbrd,
  input  logic [31:0]      cfg_vbrd,
  input  logic [FW-1:0]    cfg_whstart,
  input  logic [31:0]      cfg_wvstart,
  input  logic [31:0]      cfg_wsize,
  input  logic [31:0]      cfg_wincfg,
  input  logic [31:0]      cfg_mode,
  input  logic [31:0]      cfg_sync,
  input  logic [RGB_W-1:0] cfg_border_rgb,
  output rtg_cfg_t         act,
  output logic [RGB_W-1:0] act_border,
  output logic             primed
);
  rtg_cfg_t         prog;
  rtg_cfg_t         act_d;
  logic [RGB_W-1:0] border_d;
  logic             primed_d;
  logic             unused_ctl_bits;

  // field extraction from the programmed words
  always_comb begin
    prog.htot     = cfg_size[FW-1:0];
    prog.vtot     = cfg_size[31:16];
    prog.hbs      = cfg_hbrd[31:16];
    prog.hbe      = cfg_hbrd[FW-1:0];
    prog.vbs      = cfg_vbrd[31:16];
    prog.vbe      = cfg_vbrd[FW-1:0];
    prog.whs      = cfg_whstart;
    prog.wv_long  = cfg_wvstart[FW-1:0];
    prog.wv_short = cfg_wvstart[31:16];
    prog.wwid     = cfg_wsize[FW-1:0];
    prog.whgt     = cfg_wsize[31:16];
    prog.pix_dbl  = cfg_wincfg[0];
    prog.blank    = cfg_wincfg[3];
    prog.scan_dbl = cfg_mode[1];
    prog.disp_en  = cfg_mode[0];
    prog.ilace    = cfg_sync[4];
    prog.video_en = cfg_sync[8];
  end

  assign unused_ctl_bits = ^{cfg_wincfg[31:4], cfg_wincfg[2:1], cfg_mode[31:2],
                             cfg_sync[31:9], cfg_sync[7:5], cfg_sync[3:0]};

  always_comb begin
    act_d    = act;
    border_d = act_border;
    primed_d = primed | load;
    if (load) begin
      act_d    = prog;
      border_d = cfg_border_rgb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act        <= '0;
      act_border <= '0;
      primed     <= 1'b0;
    end else begin
      act        <= act_d;
      act_border <= border_d;
      primed     <= primed_d;
    end
  end
endmodule

// File: rtl/rtg_scan.sv
module rtg_scan
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          primed,
  input  rtg_cfg_t      act,
  output logic [FW-1:0] h_pos,
  output logic [FW-1:0] v_pos,
  output logic          field,
  output logic          load_req
);
  logic [FW-1:0] h_d;
  logic [FW-1:0] v_d;
  logic          f_d;
  logic [FW-1:0] v_last;
  logic          line_end;
  logic          adv;

  always_comb begin
    line_end = (h_pos >= (act.htot - FW'(1)));
    // the long field of an interlaced frame carries one extra line
    v_last   = act.vtot - FW'(1) + FW'(act.ilace & ~field);
    adv      = pix_en & primed;
    h_d      = h_pos;
    v_d      = v_pos;
    f_d      = field;
    if (adv) begin
      if (line_end) begin
        h_d = '0;
        if (v_pos >= v_last) begin
          v_d = '0;
          f_d = act.ilace & ~field;
        end else begin
          v_d = v_pos + FW'(1);
          f_d = act.ilace & field;
        end
      end else begin
        h_d = h_pos + FW'(1);
        f_d = act.ilace & field;
      end
    end
    // copy shadow values on the first clock of vertical sync
    load_req = pix_en & (~primed | (line_end & (v_d == act.vbe)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_pos <= '0;
      v_pos <= '0;
      field <= 1'b0;
    end else begin
      h_pos <= h_d;
      v_pos <= v_d;
      field <= f_d;
    end
  end
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
  import rtg_pkg::*;
#(
  parameter int RGB_W = 24
) (
  input  rtg_cfg_t         act,
  input  logic [RGB_W-1:0] act_border,
  input  logic [FW-1:0]    h_pos,
  input  logic [FW-1:0]    v_pos,
  input  logic             field,
  input  logic [RGB_W-1:0] pix_rgb,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             border_act,
  output logic             window_act,
  output logic [FW-1:0]    win_x,
  output logic [FW-1:0]    win_y,
  output logic             rgb_sel_pix,
  output logic [RGB_W-1:0] rgb_out
);
  logic          hs_zone;
  logic          vs_zone;
  logic          in_rect;
  logic [FW-1:0] wv_sel;
  logic [FW:0]   ext_w;
  logic [FW:0]   ext_h;
  logic [FW:0]   dx;
  logic [FW:0]   dy;
  logic          in_wh;
  logic          in_wv;
  logic [FW-1:0] x_loc;
  logic [FW-1:0] y_loc;
  logic          color_on;
  logic          unused_borrow;

  always_comb begin
    hs_zone  = (h_pos >= act.hbe) | (h_pos < act.hbs);
    vs_zone  = (v_pos >= act.vbe) | (v_pos < act.vbs);
    in_rect  = ~hs_zone & ~vs_zone;
    hsync_n  = ~(act.video_en & hs_zone);
    vsync_n  = ~(act.video_en & vs_zone);

    wv_sel   = field ? act.wv_short : act.wv_long;
    ext_w    = {1'b0, act.wwid} << act.pix_dbl;
    ext_h    = {1'b0, act.whgt} << act.scan_dbl;
    dx       = {1'b0, h_pos} - {1'b0, act.whs};
    dy       = {1'b0, v_pos} - {1'b0, wv_sel};
    in_wh    = (h_pos >= act.whs) & (dx < ext_w);
    in_wv    = (v_pos >= wv_sel) & (dy < ext_h);
    x_loc    = dx[FW-1:0] >> act.pix_dbl;
    y_loc    = dy[FW-1:0] >> act.scan_dbl;

    window_act  = in_rect & in_wh & in_wv & ~act.blank;
    border_act  = in_rect & ~window_act;
    rgb_sel_pix = window_act;
    win_x       = window_act ? x_loc : '0;
    if (!window_act)    win_y = '0;
    else if (act.ilace) win_y = {y_loc[FW-2:0], field};
    else                win_y = y_loc;

    color_on = act.video_en & act.disp_en;
    if (!color_on)       rgb_out = '0;
    else if (window_act) rgb_out = pix_rgb;
    else if (border_act) rgb_out = act_border;
    else                 rgb_out = '0;
  end

  assign unused_borrow = dx[FW] ^ dy[FW];
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic [31:0]      cfg_size,
  input  logic [31:0]      cfg_hbrd,
  input  logic [31:0]      cfg_vbrd,
  input  logic [FW-1:0]    cfg_whstart,
  input  logic [31:0]      cfg_wvstart,
  input  logic [31:0]      cfg_wsize,
  input  logic [31:0]      cfg_wincfg,
  input  logic [31:0]      cfg_mode,
  input  logic [31:0]      cfg_sync,
  input  logic [RGB_W-1:0] cfg_border_rgb,
  input  logic [RGB_W-1:0] pix_rgb,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             border_act,
  output logic             window_act,
  output logic             field_odd,
  output logic [FW-1:0]    win_x,
  output logic [FW-1:0]    win_y,
  output logic             rgb_sel_pix,
  output logic [RGB_W-1:0] rgb_out
);
  rtg_cfg_t         act_cfg;
  logic [RGB_W-1:0] act_border;
  logic             primed;
  logic             load_req;
  logic [FW-1:0]    scan_h;
  logic [FW-1:0]    scan_v;

  rtg_shadow #(.RGB_W(RGB_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load_req),
    .cfg_size(cfg_size), .cfg_hbrd(cfg_hbrd), .cfg_vbrd(cfg_vbrd),
    .cfg_whstart(cfg_whstart), .cfg_wvstart(cfg_wvstart), .cfg_wsize(cfg_wsize),
    .cfg_wincfg(cfg_wincfg), .cfg_mode(cfg_mode), .cfg_sync(cfg_sync),
    .cfg_border_rgb(cfg_border_rgb),
    .act(act_cfg), .act_border(act_border), .primed(primed)
  );

  rtg_scan u_scan (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .primed(primed), .act(act_cfg),
    .h_pos(scan_h), .v_pos(scan_v), .field(field_odd), .load_req(load_req)
  );

  rtg_decode #(.RGB_W(RGB_W)) u_decode (
    .act(act_cfg), .act_border(act_border), .h_pos(scan_h), .v_pos(scan_v),
    .field(field_odd), .pix_rgb(pix_rgb),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .border_act(border_act),
    .window_act(window_act), .win_x(win_x), .win_y(win_y),
    .rgb_sel_pix(rgb_sel_pix), .rgb_out(rgb_out)
  );
endmodule

// File: rtl/rtg_chk.sv
module rtg_chk
  import rtg_pkg::*;
#(
  parameter int RGB_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             primed,
  input logic             load_req,
  input rtg_cfg_t         act,
  input logic [FW-1:0]    h_pos,
  input logic             hsync_n,
  input logic             vsync_n,
  input logic             border_act,
  input logic             window_act,
  input logic [RGB_W-1:0] rgb_out
);
  // R1
  hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(h_pos));

  // R2
  unprimed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> (hsync_n && vsync_n && rgb_out == '0));

  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !load_req) |=> $stable(act));

  // R4
  sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (window_act || border_act) |-> (hsync_n && vsync_n));

  // R6
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act.blank |-> !window_act);

  // R11
  dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act.disp_en |-> (rgb_out == '0));
endmodule

bind raster_timing_gen rtg_chk #(.RGB_W(RGB_W)) u_rtg_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .primed(primed),
  .load_req(load_req), .act(act_cfg), .h_pos(scan_h),
  .hsync_n(hsync_n), .vsync_n(vsync_n), .border_act(border_act),
  .window_act(window_act), .rgb_out(rgb_out)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_en;
  logic [31:0] cfg_size, cfg_hbrd, cfg_vbrd, cfg_wvstart, cfg_wsize;
  logic [31:0] cfg_wincfg, cfg_mode, cfg_sync;
  logic [15:0] cfg_whstart;
  logic [23:0] cfg_border_rgb, pix_rgb;
  logic        hsync_n, vsync_n, border_act, window_act, field_odd, rgb_sel_pix;
  logic [15:0] win_x, win_y;
  logic [23:0] rgb_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] rnd = 32'h1357_9bdf;

  // reference model state
  int m_primed, m_h, m_v, m_f;
  int a_htot, a_vtot, a_hbs, a_hbe, a_vbs, a_vbe, a_whs, a_wvl, a_wvs, a_ww, a_wh;
  int a_pd, a_blank, a_sd, a_de, a_il, a_ve, a_brd;
  int cnt_rgb_nz, cnt_hs_low, cnt_win, cnt_brd;

  always #2 clk = ~clk;

  raster_timing_gen u_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .cfg_size(cfg_size), .cfg_hbrd(cfg_hbrd), .cfg_vbrd(cfg_vbrd),
    .cfg_whstart(cfg_whstart), .cfg_wvstart(cfg_wvstart), .cfg_wsize(cfg_wsize),
    .cfg_wincfg(cfg_wincfg), .cfg_mode(cfg_mode), .cfg_sync(cfg_sync),
    .cfg_border_rgb(cfg_border_rgb), .pix_rgb(pix_rgb),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .border_act(border_act),
    .window_act(window_act), .field_odd(field_odd), .win_x(win_x), .win_y(win_y),
    .rgb_sel_pix(rgb_sel_pix), .rgb_out(rgb_out)
  );

  task automatic m_reset();
    m_primed = 0; m_h = 0; m_v = 0; m_f = 0;
    a_htot = 0; a_vtot = 0; a_hbs = 0; a_hbe = 0; a_vbs = 0; a_vbe = 0;
    a_whs = 0; a_wvl = 0; a_wvs = 0; a_ww = 0; a_wh = 0;
    a_pd = 0; a_blank = 0; a_sd = 0; a_de = 0; a_il = 0; a_ve = 0; a_brd = 0;
  endtask

  task automatic m_load();
    a_htot = int'(cfg_size[15:0]);   a_vtot = int'(cfg_size[31:16]);
    a_hbs  = int'(cfg_hbrd[31:16]);  a_hbe  = int'(cfg_hbrd[15:0]);
    a_vbs  = int'(cfg_vbrd[31:16]);  a_vbe  = int'(cfg_vbrd[15:0]);
    a_whs  = int'(cfg_whstart);
    a_wvl  = int'(cfg_wvstart[15:0]); a_wvs = int'(cfg_wvstart[31:16]);
    a_ww   = int'(cfg_wsize[15:0]);  a_wh   = int'(cfg_wsize[31:16]);
    a_pd = int'(cfg_wincfg[0]); a_blank = int'(cfg_wincfg[3]);
    a_sd = int'(cfg_mode[1]);   a_de    = int'(cfg_mode[0]);
    a_il = int'(cfg_sync[4]);   a_ve    = int'(cfg_sync[8]);
    a_brd = int'(cfg_border_rgb);
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else if (pix_en) begin
      if (m_primed == 0) begin
        m_load();
        m_primed = 1;
      end else begin
        int nh, nv, nf, last;
        bit wrap_line;
        wrap_line = (m_h >= a_htot - 1);
        last = a_vtot - 1 + ((a_il != 0 && m_f == 0) ? 1 : 0);
        nv = m_v;
        nf = (a_il != 0) ? m_f : 0;
        if (wrap_line) begin
          nh = 0;
          if (m_v >= last) begin
            nv = 0;
            nf = (a_il != 0) ? 1 - m_f : 0;
          end else nv = m_v + 1;
        end else nh = m_h + 1;
        m_h = nh; m_v = nv; m_f = nf;
        if (wrap_line && nv == a_vbe) m_load();
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    bit hs, vs, inr, wh, wv, win, brd;
    int wvs, wx, wy, kx, ky;
    longint rgb;
    hs  = (m_h >= a_hbe) || (m_h < a_hbs);
    vs  = (m_v >= a_vbe) || (m_v < a_vbs);
    inr = !hs && !vs;
    wvs = (m_f != 0) ? a_wvs : a_wvl;
    kx  = (a_pd != 0) ? 2 : 1;
    ky  = (a_sd != 0) ? 2 : 1;
    wh  = (m_h >= a_whs) && (m_h - a_whs < a_ww * kx);
    wv  = (m_v >= wvs) && (m_v - wvs < a_wh * ky);
    win = inr && wh && wv && (a_blank == 0);
    brd = inr && !win;
    wx  = win ? (m_h - a_whs) / kx : 0;
    wy  = 0;
    if (win) begin
      wy = (m_v - wvs) / ky;
      if (a_il != 0) wy = wy * 2 + m_f;
    end
    if (a_ve == 0 || a_de == 0) rgb = 0;
    else if (win) rgb = longint'(pix_rgb);
    else if (brd) rgb = a_brd;
    else rgb = 0;
    chk("R1 R4 hsync_n", hsync_n, !(a_ve != 0 && hs));
    chk("R1 R4 vsync_n", vsync_n, !(a_ve != 0 && vs));
    chk("R3 R5 R6 window_act", window_act, win);
    chk("R5 R6 border_act", border_act, brd);
    chk("R9 field_odd", field_odd, m_f);
    chk("R7 R12 win_x", win_x, wx);
    chk("R8 R9 R12 win_y", win_y, wy);
    chk("R10 rgb_sel_pix", rgb_sel_pix, win);
    chk("R3 R10 R11 rgb_out", rgb_out, rgb);
    if (rgb_out != 0) cnt_rgb_nz++;
    if (!hsync_n) cnt_hs_low++;
    if (window_act) cnt_win++;
    if (border_act) cnt_brd++;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic run(input int n, input int pat, input bit churn);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      rnd = nxt(rnd);
      pix_rgb = rnd[23:0];
      case (pat)
        1: pix_en = ((i % 3) != 2);
        2: pix_en = ((i % 2) == 0);
        default: pix_en = 1'b1;
      endcase
      if (churn) begin
        cfg_wincfg = {28'd0, rnd[25], 2'b00, rnd[24]};
        cfg_mode = {30'd0, rnd[26], rnd[27]};
        cfg_sync = {23'd0, 1'b1, 3'd0, rnd[28], 4'd0};
        cfg_border_rgb = rnd[31:8];
        cfg_wvstart = {14'd0, rnd[30:29], 14'd0, rnd[5:4]} + 32'h0002_0002;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; pix_en = 1'b0; pix_rgb = '0;
    cfg_size = {16'd12, 16'd20}; cfg_hbrd = {16'd4, 16'd18}; cfg_vbrd = {16'd2, 16'd11};
    cfg_whstart = 16'd6; cfg_wvstart = {16'd4, 16'd3}; cfg_wsize = {16'd4, 16'd8};
    cfg_wincfg = 32'd0; cfg_mode = 32'd1; cfg_sync = 32'h100; cfg_border_rgb = 24'h123456;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 hsync_n in reset", hsync_n, 1);
    chk("R2 vsync_n in reset", vsync_n, 1);
    chk("R2 rgb_out in reset", rgb_out, 0);
    chk("R2 window_act in reset", window_act, 0);
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 still idle without enable", hsync_n, 1);
    pix_en = 1'b1;
    @(negedge clk);
    // first enabled clock loaded the set; column 0 lies in horizontal sync
    chk("R2 sync live after first load", hsync_n, 0);
    run(600, 0, 0);
    // R7 R8: doubling, changed mid-field
    cfg_wincfg = 32'd1; cfg_mode = 32'd3; cfg_wsize = {16'd3, 16'd5};
    cfg_border_rgb = 24'hABCDEF;
    run(700, 1, 0);
    // R9: interlace with thinned enable
    cfg_sync = 32'h110; cfg_wincfg = 32'd0; cfg_mode = 32'd1; cfg_wsize = {16'd4, 16'd8};
    run(1800, 2, 0);
    // writes on every clock, some landing on the loading edge
    run(1500, 0, 1);
    // R6: blank
    cfg_wincfg = 32'h8; cfg_mode = 32'd1; cfg_sync = 32'h100; cfg_wvstart = {16'd4, 16'd3};
    run(400, 0, 0);
    cnt_win = 0; cnt_brd = 0;
    run(300, 0, 0);
    chk("R6 no window while blanked", cnt_win, 0);
    chk("R6 border covers rectangle", (cnt_brd > 0) ? 1 : 0, 1);
    // R11: display enable off
    cfg_wincfg = 32'd0; cfg_mode = 32'd0;
    run(400, 0, 0);
    cnt_rgb_nz = 0; cnt_hs_low = 0;
    run(300, 0, 0);
    chk("R11 dark with display off", cnt_rgb_nz, 0);
    chk("R11 sync running with display off", (cnt_hs_low > 0) ? 1 : 0, 1);
    // R11: video enable off
    cfg_mode = 32'd1; cfg_sync = 32'h0;
    run(400, 0, 0);
    cnt_rgb_nz = 0; cnt_hs_low = 0;
    run(300, 0, 0);
    chk("R11 dark with video off", cnt_rgb_nz, 0);
    chk("R4 sync held high with video off", cnt_hs_low, 0);
    // R1: field total shrinks below the line where the set is copied
    cfg_sync = 32'h100; cfg_size = {16'd8, 16'd20}; cfg_vbrd = {16'd1, 16'd7};
    run(800, 1, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule